// File: doc/BRIEF.md
# Receive Bit FIFO with Fill Interrupt

This block buffers up to sixteen received data bits, one bit per entry, between the receiver's clock recovery and a host. A bit is stored each time the recovered clock strobe fires while the post-sync write enable is high and buffered mode is on. The host drains the buffer serially. It holds its select line low and toggles a read clock, and each rising read-clock edge presents the oldest stored bit on the data output.

A 4-bit programmable level drives an active-high fill interrupt. The interrupt is high whenever the number of stored bits is at or above that level, and a level of zero behaves as one. A full indication goes to the wake-up event logic. A sticky flag records any bit that was lost because the buffer was full. When buffered mode is off, the received bit and the recovered strobe pass straight to the outputs and the buffer is left untouched. When the analog data path is selected, no bits are stored.

All inputs are synchronous to `clk_i`. The read clock is sampled, and a pop happens on the cycle its sampled value is first seen high.

Top module: `rxbit_fifo`

## Requirements
- R1: The buffer holds up to 16 bits, and the host reads them out in the order they were written. Each pop updates `data_o` at the clock edge where the pop is sampled.
- R2: `fill_irq_o` is 1 exactly when the stored count is greater than or equal to the effective limit.
- R3: `fill_irq_o` follows the limit and the count combinationally. It drops in the same cycle that the count, or a change of `limit_i`, puts the count below the limit.
- R4: A `limit_i` value of 0 acts as a limit of 1.
- R5: A pop happens only when `fifo_en_i`=1, `sel_ni`=0 and `rd_clk_i` is sampled 1 after being sampled 0. With `sel_ni`=1, read-clock edges have no effect.
- R6: With `fifo_en_i`=0, `data_o` equals `rx_bit_i`, `dclk_o` equals `rx_strobe_i`, and nothing is written or popped. With `fifo_en_i`=1, `dclk_o` is 0.
- R7: With `analog_sel_i`=1, no bit is written.
- R8: A bit is written only in a cycle where both `rx_strobe_i` and `wr_en_i` are 1.
- R9: `full_wake_o` is 1 when 16 bits are stored. A write into a full buffer with no pop in the same cycle is dropped and sets `ovf_o`. `ovf_o` stays set until a cycle with `ovf_clr_i`=1 and no new drop; a new drop wins over the clear.
- R10: When a pop and an accepted write happen in the same cycle, the count is unchanged. This includes a full buffer, where the write is then accepted.
- R11: A pop request on an empty buffer changes nothing, and `data_o` holds its last value.
- R12: After reset the buffer is empty, `fill_irq_o`, `full_wake_o` and `ovf_o` are 0, and in buffered mode `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = buffered mode, 0 = direct pass-through |
| analog_sel_i | input | 1 | Analog data path selected; blocks writes |
| wr_en_i | input | 1 | Write enable after sync detection |
| rx_bit_i | input | 1 | Recovered data bit |
| rx_strobe_i | input | 1 | Recovered clock strobe, one cycle per bit |
| sel_ni | input | 1 | Host read select, active low |
| rd_clk_i | input | 1 | Host read clock, sampled |
| limit_i | input | 4 | Fill interrupt level |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| data_o | output | 1 | Popped bit, or `rx_bit_i` in direct mode |
| dclk_o | output | 1 | `rx_strobe_i` in direct mode, else 0 |
| fill_irq_o | output | 1 | Fill interrupt, active high |
| full_wake_o | output | 1 | Buffer full wake event |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
On every cycle the assertions check the following:
- the count moves by at most one per cycle;
- direct mode and the analog path never grow the count;
- a simultaneous pop and accepted write leave the count unchanged;
- a drop on a full buffer leaves it full and sets the overflow flag, which then stays set without a clear;
- the full event implies the interrupt.

Only the bench scenarios can show that bits leave in write order, that the limit-zero rule applies, and that the interrupt reacts combinationally to a limit change. The same holds for the behaviour of pass-through and empty-pop, which the bench checks against its own queue model.

// File: rtl/rxbf_pkg.sv
package rxbf_pkg;
  // Effective fill level: zero acts as one.
  function automatic logic [3:0] rxbf_eff_limit(input logic [3:0] lim);
    return (lim == '0) ? 4'd1 : lim;
  endfunction
endpackage

// File: rtl/rxbf_edge.sv
module rxbf_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/rxbf_store.sv
module rxbf_store #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          bit_i,
  output logic          bit_o,
  output logic [CW-1:0] cnt_o
);
  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    wptr_q, rptr_q;
  logic             dout_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      dout_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (push_i) begin
        mem_q[wptr_q] <= bit_i;
        wptr_q        <= nxt(wptr_q);
      end
      if (pop_i) begin
        dout_q <= mem_q[rptr_q];
        rptr_q <= nxt(rptr_q);
      end
      unique case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign bit_o = dout_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rxbf_level.sv
module rxbf_level #(
  parameter int unsigned CW = 5,
  parameter int unsigned LW = 4
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [LW-1:0] limit_i,
  output logic          irq_o
);
  logic [LW-1:0] eff;
  always_comb begin
    eff   = (limit_i == '0) ? LW'(1) : limit_i;
    irq_o = (cnt_i >= CW'(eff));
  end
endmodule

// File: rtl/rxbit_fifo.sv
module rxbit_fifo #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned LIMIT_W = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               analog_sel_i,
  input  logic               wr_en_i,
  input  logic               rx_bit_i,
  input  logic               rx_strobe_i,
  input  logic               sel_ni,
  input  logic               rd_clk_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               ovf_clr_i,
  output logic               data_o,
  output logic               dclk_o,
  output logic               fill_irq_o,
  output logic               full_wake_o,
  output logic               ovf_o
);
  logic          rd_rise, rd_pop, wr_req, wr_acc, pop_bit, ovf_q;
  logic [CW-1:0] cnt;

  rxbf_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (rd_clk_i),
    .rise_o(rd_rise)
  );

  assign rd_pop = fifo_en_i & ~sel_ni & rd_rise & (cnt != '0);
  assign wr_req = fifo_en_i & ~analog_sel_i & wr_en_i & rx_strobe_i;
  // Full buffer accepts only if a slot frees in the same cycle.
  assign wr_acc = wr_req & ((cnt != CW'(DEPTH)) | rd_pop);

  rxbf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(wr_acc),
    .pop_i (rd_pop),
    .bit_i (rx_bit_i),
    .bit_o (pop_bit),
    .cnt_o (cnt)
  );

  rxbf_level #(.CW(CW), .LW(LIMIT_W)) u_level (
    .cnt_i  (cnt),
    .limit_i(limit_i),
    .irq_o  (fill_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovf_q <= 1'b0;
    else if (wr_req && !wr_acc) ovf_q <= 1'b1;
    else if (ovf_clr_i)         ovf_q <= 1'b0;
  end

  assign data_o      = fifo_en_i ? pop_bit : rx_bit_i;
  assign dclk_o      = fifo_en_i ? 1'b0 : rx_strobe_i;
  assign full_wake_o = (cnt == CW'(DEPTH));
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/rxbit_fifo_chk.sv
module rxbit_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          analog_sel_i,
  input logic          ovf_clr_i,
  input logic          fill_irq_o,
  input logic          full_wake_o,
  input logic          ovf_o,
  input logic [CW-1:0] cnt,
  input logic          rd_pop,
  input logic          wr_req,
  input logic          wr_acc
);
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || (cnt == $past(cnt) - CW'(1)));

  a_r6_direct_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> $stable(cnt));

  a_r7_analog_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    analog_sel_i |=> (cnt <= $past(cnt)));

  a_r9_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && full_wake_o && !rd_pop) |=> (full_wake_o && ovf_o));

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  a_r10_simul_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pop && wr_acc) |=> $stable(cnt));

  a_r2_full_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_wake_o |-> fill_irq_o);
endmodule

bind rxbit_fifo rxbit_fifo_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/rxbit_fifo_tb_top.sv
`timescale 1ns/1ps
module rxbit_fifo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, an = 1'b0, wen = 1'b0, bi = 1'b0, stb = 1'b0;
  logic sel_n = 1'b1, rclk = 1'b0, clr = 1'b0;
  logic [3:0] lim = 4'd8;
  logic dout, dclk, irq, full, ovf;

  int checks = 0, fails = 0;
  bit q[$];
  bit m_dout = 1'b0, m_ovf = 1'b0, m_rprev = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  rxbit_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(en), .analog_sel_i(an),
    .wr_en_i(wen), .rx_bit_i(bi), .rx_strobe_i(stb), .sel_ni(sel_n),
    .rd_clk_i(rclk), .limit_i(lim), .ovf_clr_i(clr), .data_o(dout),
    .dclk_o(dclk), .fill_irq_o(irq), .full_wake_o(full), .ovf_o(ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(logic [3:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  task automatic check_outs(string tag);
    chk({tag, "/R2 irq"}, irq, (q.size() >= eff(lim)));
    chk({tag, "/R9 full"}, full, (q.size() == 16));
    chk({tag, "/R9 ovf"}, ovf, m_ovf);
    chk({tag, "/R1 data"}, dout, en ? m_dout : bi);
    chk({tag, "/R6 dclk"}, dclk, en ? 1'b0 : stb);
  endtask

  // One clock: drive at negedge, model the edge, check after it.
  task automatic cyc(bit e, bit a, bit w, bit s, bit b, bit sn, bit rc,
                     logic [3:0] l, bit c, string tag);
    bit pop, req, acc;
    @(negedge clk);
    en = e; an = a; wen = w; stb = s; bi = b; sel_n = sn; rclk = rc; lim = l; clr = c;
    pop = e && !sn && rc && !m_rprev && (q.size() > 0);
    req = e && !a && w && s;
    acc = req && ((q.size() < 16) || pop);
    @(posedge clk);
    #1;
    if (pop) m_dout = q.pop_front();
    if (acc) q.push_back(b);
    if (req && !acc) m_ovf = 1'b1;
    else if (c) m_ovf = 1'b0;
    m_rprev = rc;
    check_outs(tag);
  endtask

  task automatic wr(bit b, string tag);
    cyc(1, 0, 1, 1, b, 1, 0, lim, 0, tag);
  endtask

  task automatic rd(string tag);
    cyc(1, 0, 0, 0, 0, 0, 1, lim, 0, tag);
    cyc(1, 0, 0, 0, 0, 0, 0, lim, 0, tag);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    void'($urandom(32'd1234));
    #12 rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 irq", irq, 0); chk("R12 full", full, 0);
    chk("R12 ovf", ovf, 0); chk("R12 data", dout, 0);

    // R1/R2 fill with pattern, limit 8
    pat = 16'hB3C5;
    for (int i = 0; i < 16; i++) wr(pat[i], "R1 fill");
    chk("R9 full after 16", full, 1);
    // R9 overflow drop
    wr(1, "R9 drop");
    chk("R9 ovf set", ovf, 1);
    cyc(1, 0, 0, 0, 0, 1, 0, lim, 0, "R9 sticky");
    chk("R9 ovf sticky", ovf, 1);
    cyc(1, 0, 0, 0, 0, 1, 0, lim, 1, "R9 clear");
    chk("R9 ovf cleared", ovf, 0);
    // R10 pop + write while full
    cyc(1, 0, 1, 1, 0, 0, 1, lim, 0, "R10 simul");
    chk("R10 full held", full, 1);
    cyc(1, 0, 0, 0, 0, 0, 0, lim, 0, "R10 idle");
    // R5 select high: read edges ignored
    cyc(1, 0, 0, 0, 0, 1, 1, lim, 0, "R5 sel high");
    cyc(1, 0, 0, 0, 0, 1, 0, lim, 0, "R5 sel high");
    chk("R5 still full", full, 1);
    // R3 combinational limit change
    for (int i = 0; i < 9; i++) rd("R1 drain");
    @(negedge clk); lim = 4'd8; #1;
    chk("R3 irq at 7<8", irq, 0);
    lim = 4'd7; #1;
    chk("R3 irq at 7>=7", irq, 1);
    rd("R3 drop below");
    chk("R3 irq fell", irq, 0);
    // R4 limit 0
    lim = 4'd0;
    while (q.size() > 0) rd("R1 drain");
    chk("R4 empty irq", irq, 0);
    // R11 empty pop
    rd("R11 empty pop");
    wr(1, "R4 one bit");
    chk("R4 limit0 irq", irq, 1);
    // R6 pass-through, R7 analog, R8 strobe without enable
    cyc(0, 0, 1, 1, 0, 0, 1, lim, 0, "R6 direct");
    cyc(0, 0, 1, 1, 1, 0, 0, lim, 0, "R6 direct");
    cyc(1, 1, 1, 1, 0, 1, 0, lim, 0, "R7 analog");
    cyc(1, 0, 0, 1, 0, 1, 0, lim, 0, "R8 no wen");
    cyc(1, 0, 1, 0, 0, 1, 0, lim, 0, "R8 no stb");
    chk("R7 count one", q.size(), 1);
    rd("R8 readback");
    chk("R8 readback", dout, 1);
    chk("R6 empty", irq, 0);

    // random
    for (int i = 0; i < 4000; i++) begin
      bit e = ($urandom % 16) != 0;
      bit a = ($urandom % 20) == 0;
      logic [3:0] l = (($urandom % 30) == 0) ? 4'($urandom) : lim;
      cyc(e, a, $urandom % 4 != 0, $urandom % 2, $urandom % 2,
          $urandom % 5 == 0, $urandom % 2, l, $urandom % 8 == 0, "rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule